// File: doc/BRIEF.md
# Serial Audio Link Power-Down Controller

This block sits beside the frame shifter of a serial audio codec link and governs the link's low-power state. It inspects every codec register write that is placed into an outgoing frame. When it sees the power-down command, it trims that frame's slot tag so that only the command and data slots are marked valid. After that frame has gone out, it takes over the controller-driven sync and serial-out lines and holds them low. The codec is then free to stop its bit clock, and the controller's state does not depend on that clock while the link is halted.

Software can bring the link back in three ways. A warm reset and an external wake event both raise sync for a fixed time measured in system clocks. A cold reset pulls the codec reset line low for the same time. In every case the controller then holds the lines low until it has counted a number of rising bit-clock edges, and only then does it hand the lines back to the frame shifter. Power-down entry is refused and flagged unless the shut-off control bit is set. Wake requests that arrive while the link is running are ignored.

Top module: `alink_pwr_ctl`

## Requirements
- R1: After reset the link is active: `link_active`=1, `codec_rst_n`=1, `sync_out` follows `sync_in`, `sdout_out` follows `sdout_in`, and `pd_refused`=0.
- R2: The power-down command is a write with `wr_valid`=1, `wr_addr`=7'h26 and `wr_data` bit 12 set. When it arrives in the active state with `shut_off_en`=1, `tag_out` equals `tag_in` AND 13'h0007 in that same cycle, keeping bit 0 (frame valid) and bits 1 and 2 (slots 1 and 2). At all other times `tag_out` equals `tag_in`.
- R3: After an accepted power-down command, the next `frame_done` pulse halts the link. From the following cycle `link_active`=0, `sync_out`=0 and `sdout_out`=0.
- R4: A write to 7'h26 with bit 12 clear, or a write to any other address, does not change the state. A later `frame_done` leaves the link active.
- R5: A power-down command seen while `shut_off_en`=0 is refused. `tag_out` is unchanged, `pd_refused` is 1 for exactly the next cycle, and the link stays active.
- R6: While halted, bit-clock activity alone does not change the outputs.
- R7: A `warm_req` pulse while halted drives `sync_out` high for exactly PULSE_CYC cycles (CLK_MHZ × PULSE_US) with `codec_rst_n`=1.
- R8: An `ext_wake` pulse while halted produces the same sync pulse as a warm reset.
- R9: A `cold_req` pulse while halted drives `codec_rst_n` low for exactly PULSE_CYC cycles while `sync_out` stays 0.
- R10: If `cold_req` arrives in the same cycle as `warm_req` or `ext_wake`, only the cold reset is performed and no sync pulse appears.
- R11: `warm_req`, `ext_wake` and `cold_req` have no effect while the link is active.
- R12: After either reset pulse, `sync_out`=`sdout_out`=0 and `link_active`=0 until WAKE_EDGES rising bit-clock edges have been seen. After that the link is active again and the lines follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shut_off_en | input | 1 | Software permission to power the link down |
| wr_valid | input | 1 | A codec register write is carried in the current frame |
| wr_addr | input | 7 | Codec register address of that write |
| wr_data | input | 16 | Data of that write |
| tag_in | input | 13 | Slot-valid tag from the frame builder |
| tag_out | output | 13 | Slot-valid tag after power-down trimming |
| frame_done | input | 1 | Pulse at the end of an outgoing frame |
| sync_in | input | 1 | Sync value from the frame shifter |
| sdout_in | input | 1 | Serial-out value from the frame shifter |
| bit_clk | input | 1 | Bit clock from the codec (asynchronous) |
| ext_wake | input | 1 | External wake event |
| warm_req | input | 1 | Warm reset request |
| cold_req | input | 1 | Cold reset request |
| sync_out | output | 1 | Sync line drive value |
| sdout_out | output | 1 | Serial-out line drive value |
| codec_rst_n | output | 1 | Codec reset line, active low |
| link_active | output | 1 | 1 when the link is running, 0 while halted or waking |
| pd_refused | output | 1 | One-cycle flag for a refused power-down command |

## Verification
Two collisions can happen in the same cycle. The first is a cold reset arriving together with a warm reset or an external wake. The bench raises both requests on one clock while the link is halted. It expects exactly one reset-line pulse in its scoreboard, and any sync pulse would be an unexpected item that fails the check. The second is a wake request arriving together with normal traffic while the link is active. There the bench checks that the lines still follow the frame shifter and that no pulse of either kind is ever recorded.

// File: rtl/alink_pwr_pkg.sv
package alink_pwr_pkg;

    localparam int TAG_W    = 13;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam logic [ADDR_W-1:0] PD_REG_ADDR = 7'h26;
    localparam int PD_BIT   = 12;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_ARMED,
        ST_HALT,
        ST_WARM,
        ST_COLD,
        ST_WAIT
    } link_st_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_WARM,
        WK_COLD
    } wake_kind_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } codec_wr_t;

    // Frame-valid bit plus the command and data slots.
    function automatic logic [TAG_W-1:0] pd_tag_mask();
        logic [TAG_W-1:0] m;
        m = '0;
        for (int i = 0; i < 3; i++) m[i] = 1'b1;
        return m;
    endfunction

    // A cold reset outranks the sync-based wake paths.
    function automatic wake_kind_e pick_wake(input logic cold, input logic warm,
                                             input logic ext);
        if (cold)             return WK_COLD;
        else if (warm || ext) return WK_WARM;
        else                  return WK_NONE;
    endfunction

endpackage

// File: rtl/alink_pd_decode.sv
module alink_pd_decode
    import alink_pwr_pkg::*;
(
    input  codec_wr_t        wr,
    input  logic             shut_off_en,
    input  logic             allow,
    input  logic [TAG_W-1:0] tag_in,
    output logic             pd_hit,
    output logic             pd_ok,
    output logic [TAG_W-1:0] tag_out
);
    always_comb begin
        pd_hit  = wr.valid && (wr.addr == PD_REG_ADDR) && wr.data[PD_BIT];
        pd_ok   = pd_hit && shut_off_en && allow;
        tag_out = pd_ok ? (tag_in & pd_tag_mask()) : tag_in;
    end
endmodule

// File: rtl/alink_pulse_timer.sv
module alink_pulse_timer #(
    parameter int PULSE_CYC = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(PULSE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == LAST) busy <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = busy && (cnt_q == LAST);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q < CW'(PULSE_CYC)));
endmodule

// File: rtl/alink_bclk_mon.sv
module alink_bclk_mon #(
    parameter int WAKE_EDGES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    input  logic clr,
    output logic woke
);
    localparam int EW = $clog2(WAKE_EDGES + 1);

    logic [SYNC_STAGES:0] sh_q;
    logic [EW-1:0]        ecnt_q;
    logic                 rise;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], bit_clk};
    end

    assign rise = sh_q[SYNC_STAGES-1] && !sh_q[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst || clr)                          ecnt_q <= '0;
        else if (rise && ecnt_q < EW'(WAKE_EDGES)) ecnt_q <= ecnt_q + 1'b1;
    end

    assign woke = (ecnt_q == EW'(WAKE_EDGES));

    // R12
    edge_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ecnt_q == '0));
endmodule

// File: rtl/alink_pwr_ctl.sv
module alink_pwr_ctl
    import alink_pwr_pkg::*;
#(
    parameter int CLK_MHZ    = 125,
    parameter int PULSE_US   = 1,
    parameter int WAKE_EDGES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shut_off_en,
    input  logic             wr_valid,
    input  logic [6:0]       wr_addr,
    input  logic [15:0]      wr_data,
    input  logic [12:0]      tag_in,
    output logic [12:0]      tag_out,
    input  logic             frame_done,
    input  logic             sync_in,
    input  logic             sdout_in,
    input  logic             bit_clk,
    input  logic             ext_wake,
    input  logic             warm_req,
    input  logic             cold_req,
    output logic             sync_out,
    output logic             sdout_out,
    output logic             codec_rst_n,
    output logic             link_active,
    output logic             pd_refused
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;

    link_st_e   st_q, st_d;
    codec_wr_t  wr;
    wake_kind_e wk;
    logic       pd_hit, pd_ok, allow;
    logic       tmr_start, tmr_busy, tmr_done;
    logic       woke, pd_ref_q;

    assign wr    = '{valid: wr_valid, addr: wr_addr, data: wr_data};
    assign allow = (st_q == ST_ACTIVE);
    assign wk    = pick_wake(cold_req, warm_req, ext_wake);

    alink_pd_decode u_dec (
        .wr          (wr),
        .shut_off_en (shut_off_en),
        .allow       (allow),
        .tag_in      (tag_in),
        .pd_hit      (pd_hit),
        .pd_ok       (pd_ok),
        .tag_out     (tag_out)
    );

    alink_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    alink_bclk_mon #(.WAKE_EDGES(WAKE_EDGES)) u_bcm (
        .clk     (clk),
        .rst     (rst),
        .bit_clk (bit_clk),
        .clr     (st_q != ST_WAIT),
        .woke    (woke)
    );

    always_comb begin
        st_d      = st_q;
        tmr_start = 1'b0;
        unique case (st_q)
            ST_ACTIVE: if (pd_ok) st_d = ST_ARMED;
            ST_ARMED:  if (frame_done) st_d = ST_HALT;
            ST_HALT: begin
                if (wk == WK_COLD) begin
                    st_d = ST_COLD;
                    tmr_start = 1'b1;
                end else if (wk == WK_WARM) begin
                    st_d = ST_WARM;
                    tmr_start = 1'b1;
                end
            end
            ST_WARM:   if (tmr_done) st_d = ST_WAIT;
            ST_COLD:   if (tmr_done) st_d = ST_WAIT;
            ST_WAIT:   if (woke) st_d = ST_ACTIVE;
            default:   st_d = ST_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_ACTIVE;
            pd_ref_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            pd_ref_q <= pd_hit && !shut_off_en && allow;
        end
    end

    always_comb begin
        link_active = (st_q == ST_ACTIVE) || (st_q == ST_ARMED);
        codec_rst_n = (st_q != ST_COLD);
        sdout_out   = link_active ? sdout_in : 1'b0;
        if (link_active)          sync_out = sync_in;
        else if (st_q == ST_WARM) sync_out = 1'b1;
        else                      sync_out = 1'b0;
    end

    assign pd_refused = pd_ref_q;

    // R3
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARMED && frame_done) |=> (st_q == ST_HALT));
    // R5
    refuse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        pd_refused |-> $past(!shut_off_en && wr_valid));
    // R10
    cold_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HALT && cold_req) |=> (st_q == ST_COLD));
    // R11
    active_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ACTIVE) |=> (st_q == ST_ACTIVE || st_q == ST_ARMED));
    // R12
    wait_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT) |=> (st_q == ST_WAIT || st_q == ST_ACTIVE));
    // R7
    timer_match_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WARM || st_q == ST_COLD) |-> tmr_busy);
endmodule

// File: tb/alink_pwr_ctl_tb.sv
module alink_pwr_ctl_tb_top;
    localparam int PULSE = 125;

    logic clk = 0, rst = 1;
    logic shut_off_en = 0, wr_valid = 0, frame_done = 0;
    logic [6:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [12:0] tag_in = 13'h1FFF, tag_out;
    logic sync_in = 0, sdout_in = 0, bit_clk = 0, bclk_run = 0;
    logic ext_wake = 0, warm_req = 0, cold_req = 0;
    logic sync_out, sdout_out, codec_rst_n, link_active, pd_refused;

    int total = 0, bad = 0;
    bit finished = 0;

    typedef struct { int kind; int len; } pulse_t;  // kind 1 sync, 2 reset
    pulse_t exp_q[$];
    int srun = 0, rrun = 0;

    always #4 clk = ~clk;
    always begin
        #20;
        if (bclk_run) bit_clk = ~bit_clk;
    end

    alink_pwr_ctl dut_i (
        .clk(clk), .rst(rst), .shut_off_en(shut_off_en), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .tag_in(tag_in), .tag_out(tag_out),
        .frame_done(frame_done), .sync_in(sync_in), .sdout_in(sdout_in),
        .bit_clk(bit_clk), .ext_wake(ext_wake), .warm_req(warm_req),
        .cold_req(cold_req), .sync_out(sync_out), .sdout_out(sdout_out),
        .codec_rst_n(codec_rst_n), .link_active(link_active),
        .pd_refused(pd_refused)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic score(input int kind, input int len);
        pulse_t e;
        if (exp_q.size() == 0) begin
            chk(0, "R10 unexpected pulse", kind, 0);
        end else begin
            e = exp_q.pop_front();
            chk(e.kind == kind && e.len == len, "R7/R8/R9 pulse",
                kind * 1000 + len, e.kind * 1000 + e.len);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (!link_active && codec_rst_n && sync_out) srun++;
            else if (srun > 0) begin score(1, srun); srun = 0; end
            if (!codec_rst_n) rrun++;
            else if (rrun > 0) begin score(2, rrun); rrun = 0; end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_one(input logic [6:0] a, input logic [15:0] d,
                          input logic [12:0] exp_tag, input string req);
        @(negedge clk);
        wr_valid = 1; wr_addr = a; wr_data = d;
        #1 chk(tag_out == exp_tag, req, tag_out, exp_tag);
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic frame_pulse();
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0;
    endtask

    task automatic enter_halt();
        shut_off_en = 1;
        wr_one(7'h26, 16'h1000, 13'h0007, "R2 trimmed tag");
        chk(link_active == 1, "R3 armed still active", link_active, 1);
        frame_pulse();
        chk(!link_active && !sync_out && !sdout_out, "R3 halted low",
            {link_active, sync_out, sdout_out}, 0);
    endtask

    task automatic wake(input int kind, input bit both);
        pulse_t e;
        e.kind = (kind == 2) ? 2 : 1; e.len = PULSE;
        exp_q.push_back(e);
        @(negedge clk);
        if (kind == 2) cold_req = 1;
        if (kind == 1 || both) warm_req = 1;
        if (kind == 3) ext_wake = 1;
        @(negedge clk);
        cold_req = 0; warm_req = 0; ext_wake = 0;
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R7/R8/R9 pulse seen", exp_q.size(), 0);
        cyc(3);
        chk(!link_active && !sync_out && !sdout_out && codec_rst_n,
            "R12 waiting low", {link_active, sync_out, sdout_out, codec_rst_n}, 1);
        bclk_run = 1;
        for (int i = 0; i < 300 && !link_active; i++) @(negedge clk);
        chk(link_active == 1, "R12 active after edges", link_active, 1);
        #1 chk(sync_out == sync_in && sdout_out == sdout_in, "R12 lines follow",
               {sync_out, sdout_out}, {sync_in, sdout_in});
        bclk_run = 0;
        cyc(4);
    endtask

    initial begin
        #(8 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(3);
        @(negedge clk) rst = 0;
        sync_in = 1; sdout_in = 1;
        #1;
        chk(link_active && codec_rst_n && sync_out && sdout_out && !pd_refused,
            "R1 reset state", {link_active, codec_rst_n, sync_out, sdout_out, pd_refused},
            5'b11110);

        // R11: wake requests while active
        @(negedge clk); warm_req = 1; cold_req = 1; ext_wake = 1;
        @(negedge clk); warm_req = 0; cold_req = 0; ext_wake = 0;
        cyc(2);
        chk(link_active && codec_rst_n && sync_out == sync_in, "R11 ignored",
            {link_active, codec_rst_n, sync_out}, 3'b111);

        // R4: non-command writes
        shut_off_en = 1;
        wr_one(7'h26, 16'hEFFF, 13'h1FFF, "R4 bit clear tag");
        wr_one(7'h24, 16'h1000, 13'h1FFF, "R4 other addr tag");
        frame_pulse();
        chk(link_active == 1, "R4 still active", link_active, 1);

        // R5: refused without shut-off
        shut_off_en = 0;
        @(negedge clk);
        wr_valid = 1; wr_addr = 7'h26; wr_data = 16'h1000;
        #1 chk(tag_out == 13'h1FFF, "R5 tag unchanged", tag_out, 13'h1FFF);
        @(negedge clk); wr_valid = 0;
        chk(pd_refused == 1, "R5 refused flag", pd_refused, 1);
        @(negedge clk);
        chk(pd_refused == 0, "R5 flag one cycle", pd_refused, 0);
        frame_pulse();
        chk(link_active == 1, "R5 stays active", link_active, 1);

        // R2/R3/R6/R7
        enter_halt();
        bclk_run = 1; cyc(40); bclk_run = 0; cyc(4);
        chk(!link_active && !sync_out && !sdout_out && codec_rst_n, "R6 halt holds",
            {link_active, sync_out, sdout_out, codec_rst_n}, 1);
        wake(1, 0);

        // R8 external wake
        enter_halt();
        wake(3, 0);

        // R9 cold reset
        enter_halt();
        wake(2, 0);

        // R10 cold with warm in same cycle
        enter_halt();
        wake(2, 1);

        chk(exp_q.size() == 0 && srun == 0 && rrun == 0, "R10 no stray pulse",
            exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule